// File: doc/BRIEF.md
# APB Transfer Monitor

This block watches an APB-style peripheral bus without driving it. It follows the two-phase handshake, in which a setup cycle is followed by an access cycle. For every transfer that completes cleanly, it produces one transaction record: a single-cycle valid strobe together with the address, the direction and the data word. Downstream logic such as a scoreboard, a trace buffer or a coverage collector can then work with whole reads and writes instead of raw signal activity.

During the setup cycle the monitor captures the address, the direction and the write data. In the access cycle it compares the live bus against that captured copy. A malformed handshake is reported on a sequence-violation flag. Examples are an enable with no setup before it, or a setup that is not followed by an access. A transfer whose address, direction or write data moves between the two phases is reported on a stability-violation flag and produces no record.

Top module: `apb_txn_monitor`

## Requirements
- R1: While reset is active, and in the cycles that follow it, no partial transfer is held. An access cycle as the first cycle after reset raises `err_sequence` and produces no record. All outputs are low while reset is held with an idle bus.
- R2: A write is a setup cycle (select=1, enable=0, write=1) followed by an access cycle (select=1, enable=1) with the same address, direction and write data. In that access cycle `rec_valid`=1, `rec_write`=1, `rec_addr` is the address and `rec_data` is the write data.
- R3: A read is a setup cycle with write=0 followed by a matching access cycle. In the access cycle `rec_valid`=1, `rec_write`=0, and `rec_data` equals `bus_rdata` as seen in that same access cycle.
- R4: `rec_valid` is high only in an access cycle and never in two consecutive cycles. It is never high in a setup cycle or an idle cycle.
- R5: `bus_enable`=1 in a cycle that does not directly follow a setup cycle raises `err_sequence` in that cycle and produces no record.
- R6: A setup cycle whose next cycle is not an access (idle, another setup, or enable without select) raises `err_sequence` in that next cycle. A new setup in that cycle is still captured and can complete normally.
- R7: An access cycle whose address or direction differs from its setup cycle raises `err_stable` and produces no record.
- R8: For a write, a change of write data between setup and access raises `err_stable` and produces no record. For a read, the write-data lines are ignored and the record is still produced.
- R9: Back-to-back transfers, where each setup cycle directly follows the previous access cycle, each produce one record and raise no flag.
- R10: Idle cycles (select=0, enable=0) that do not follow a setup raise no flag and produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_write | input | 1 | Direction, 1 = write |
| bus_sel | input | 1 | Peripheral select |
| bus_enable | input | 1 | Access-phase enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data returned by the peripheral |
| rec_valid | output | 1 | One-cycle strobe for a completed transfer |
| rec_addr | output | ADDR_W | Address of the record |
| rec_write | output | 1 | Direction of the record |
| rec_data | output | DATA_W | Write data or read data of the record |
| err_sequence | output | 1 | Setup/access ordering violation |
| err_stable | output | 1 | Address, direction or write data changed across phases |

## Verification
The properties assume that the inputs are settled and free of X at every rising edge. They also assume that the bus is idle while reset is held, so that the reset cycle itself never forms half of a transfer. The bench changes inputs only on falling edges and holds select and enable low around every reset, including a reset placed between a setup and its access. Every violation in the stimulus is deliberate and is paired with an expected flag, so the properties that tie records to clean handshakes are exercised on both legal and illegal traffic.

// File: rtl/apb_txn_monitor.sv
module apb_txn_monitor #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              rec_write,
  output logic [DATA_W-1:0] rec_data,
  output logic              err_sequence,
  output logic              err_stable
);

  logic              armed_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  logic setup_now, access_now, access_ok, mismatch;

  assign setup_now  = bus_sel && !bus_enable;
  assign access_now = bus_sel && bus_enable;
  assign access_ok  = armed_q && access_now;

  assign mismatch = (bus_addr != addr_q) || (bus_write != write_q) ||
                    (write_q && (bus_wdata != wdata_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      armed_q <= setup_now;
      if (setup_now) begin
        addr_q  <= bus_addr;
        write_q <= bus_write;
        wdata_q <= bus_wdata;
      end
    end
  end

  assign rec_valid    = access_ok && !mismatch;
  assign rec_addr     = addr_q;
  assign rec_write    = write_q;
  assign rec_data     = write_q ? wdata_q : bus_rdata;
  assign err_stable   = access_ok && mismatch;
  assign err_sequence = (bus_enable && !armed_q) || (armed_q && !access_now);

endmodule

module apb_txn_monitor_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rec_valid,
  input logic [ADDR_W-1:0] rec_addr,
  input logic              rec_write,
  input logic [DATA_W-1:0] rec_data,
  input logic              err_sequence,
  input logic              err_stable
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r4_valid_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (bus_sel && bus_enable));

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  a_r2_addr_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rec_valid) |-> (rec_addr == $past(bus_addr) && rec_write == $past(bus_write)));

  a_r2_wdata_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && rec_valid && rec_write) |-> (rec_data == $past(bus_wdata)));

  a_r5_enable_without_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && bus_enable && !$past(bus_sel && !bus_enable)) |-> (err_sequence && !rec_valid));

  a_r6_setup_abandoned: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(bus_sel && !bus_enable) && !(bus_sel && bus_enable)) |-> err_sequence);

  a_r7_flags_exclude_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (!err_stable && !err_sequence));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && !bus_enable) |-> (!rec_valid && !err_stable));

endmodule

bind apb_txn_monitor apb_txn_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
  .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_wdata(bus_wdata),
  .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_write(rec_write),
  .rec_data(rec_data), .err_sequence(err_sequence), .err_stable(err_stable)
);

// File: tb/tb_apb_txn_monitor.sv
module tb_apb_txn_monitor;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_write = 1'b0, bus_sel = 1'b0, bus_enable = 1'b0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata = '0;
  logic          rec_valid, rec_write, err_sequence, err_stable;
  logic [AW-1:0] rec_addr;
  logic [DW-1:0] rec_data;

  always #2 clk = ~clk;

  apb_txn_monitor #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_write(rec_write), .rec_data(rec_data), .err_sequence(err_sequence),
    .err_stable(err_stable));

  typedef struct {
    logic          v;
    logic [AW-1:0] a;
    logic          w;
    logic [DW-1:0] d;
    logic          es;
    logic          et;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic w, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                     input logic xv, input logic [AW-1:0] xa, input logic xw, input logic [DW-1:0] xd,
                     input logic xes, input logic xet, input string tag);
    exp_t it;
    @(negedge clk);
    bus_sel = s; bus_enable = e; bus_write = w; bus_addr = a; bus_wdata = wd; bus_rdata = rd;
    it.v = xv; it.a = xa; it.w = xw; it.d = xd; it.es = xes; it.et = xet; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input logic xes, input string tag);
    cyc(0, 0, 0, '0, '0, '0, 0, '0, 0, '0, xes, 0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic first_es);
    cyc(1, 0, 1, a, d, 32'hdead, 0, '0, 0, '0, first_es, 0, "R2");
    cyc(1, 1, 1, a, d, 32'hbeef, 1, a, 1, d, 0, 0, "R2");
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1, 0, 0, a, 32'h1111, 32'h0, 0, '0, 0, '0, 0, 0, "R3");
    cyc(1, 1, 0, a, 32'h1111, d, 1, a, 0, d, 0, 0, "R3");
  endtask

  always begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(it.tag, "valid", 64'(rec_valid), 64'(it.v));
      chk(it.tag, "err_sequence", 64'(err_sequence), 64'(it.es));
      chk(it.tag, "err_stable", 64'(err_stable), 64'(it.et));
      if (it.v) begin
        chk(it.tag, "addr", 64'(rec_addr), 64'(it.a));
        chk(it.tag, "write", 64'(rec_write), 64'(it.w));
        chk(it.tag, "data", 64'(rec_data), 64'(it.d));
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(0, "R1");
    idle(0, "R1");
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1, 1, 16'h0040, 32'h5, 32'h0, 0, '0, 0, '0, 1, 0, "R1");
    idle(0, "R10");
    wr(16'h1234, 32'hcafe0001, 0);
    idle(0, "R4");
    rd(16'h0abc, 32'h87654321);
    idle(0, "R10");
    wr(16'h0001, 32'h11112222, 0);
    rd(16'h0002, 32'h33334444);
    wr(16'hfffe, 32'hffffffff, 0);
    rd(16'h0000, 32'h0);
    idle(0, "R9");
    cyc(1, 1, 0, 16'h0010, '0, '0, 0, '0, 0, '0, 1, 0, "R5");
    cyc(1, 1, 0, 16'h0010, '0, '0, 0, '0, 0, '0, 1, 0, "R5");
    cyc(0, 1, 0, 16'h0010, '0, '0, 0, '0, 0, '0, 1, 0, "R5");
    idle(0, "R10");
    cyc(1, 0, 1, 16'h0020, 32'h9, '0, 0, '0, 0, '0, 0, 0, "R6");
    idle(1, "R6");
    cyc(1, 0, 1, 16'h0030, 32'h7, '0, 0, '0, 0, '0, 0, 0, "R6");
    wr(16'h0031, 32'h8, 1);
    cyc(1, 0, 0, 16'h0050, '0, '0, 0, '0, 0, '0, 0, 0, "R6");
    cyc(0, 1, 0, 16'h0050, '0, '0, 0, '0, 0, '0, 1, 0, "R6");
    cyc(1, 0, 1, 16'h0060, 32'haa, '0, 0, '0, 0, '0, 0, 0, "R7");
    cyc(1, 1, 1, 16'h0061, 32'haa, '0, 0, '0, 0, '0, 0, 1, "R7");
    cyc(1, 0, 0, 16'h0070, '0, '0, 0, '0, 0, '0, 0, 0, "R7");
    cyc(1, 1, 1, 16'h0070, '0, '0, 0, '0, 0, '0, 0, 1, "R7");
    cyc(1, 0, 1, 16'h0080, 32'h100, '0, 0, '0, 0, '0, 0, 0, "R8");
    cyc(1, 1, 1, 16'h0080, 32'h101, '0, 0, '0, 0, '0, 0, 1, "R8");
    cyc(1, 0, 0, 16'h0090, 32'h200, '0, 0, '0, 0, '0, 0, 0, "R8");
    cyc(1, 1, 0, 16'h0090, 32'h201, 32'h55aa, 1, 16'h0090, 0, 32'h55aa, 0, 0, "R8");
    idle(0, "R10");
    cyc(1, 0, 1, 16'h00a0, 32'h3, '0, 0, '0, 0, '0, 0, 0, "R1");
    @(negedge clk); bus_sel = 0; bus_enable = 0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    q.delete();
    cyc(1, 1, 1, 16'h00a0, 32'h3, '0, 0, '0, 0, '0, 1, 0, "R1");
    idle(0, "R1");
    wr(16'h00b0, 32'h4, 0);
    idle(0, "R10");
    idle(0, "R10");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule